// File: doc/BRIEF.md
# UART Multiprocessor Address Filter

This block decides which received frames a UART receiver in 9-bit multiprocessor mode hands to its host. It sits behind the serial shifter. For each completed frame it gets one strobe together with the eight data bits and the ninth bit. It then either loads those bits into its receive buffer and raises a one-cycle accept strobe, or drops the frame.

Two 8-bit registers shape the decision, and both are written over a small register port:

- **Node address.** This is the address the node answers to.
- **Mask.** This selects which address bits take part in the comparison.

A frame can match in two ways:

- **Own address.** The frame's byte agrees with the node address wherever the mask holds a 1.
- **Broadcast address.** This is formed as node address OR mask. Every bit that is 1 in it must also be 1 in the byte. The bits that are 0 in it are ignored.

An enable input turns filtering on. When filtering is off, every frame is accepted.

Top module: `uart_mp_addr_filter`

## Requirements
- R1: After reset the node address and mask both read 0x00, the accept strobe is low, and the receive buffer holds 0x00 with its ninth bit 0.
- R2: A write with `cfg_sel`=0 loads the node address and a write with `cfg_sel`=1 loads the mask. `cfg_rdata` shows the node address when `cfg_sel`=0 and the mask when `cfg_sel`=1.
- R3: With `filt_en`=0, every frame is accepted whatever its byte and ninth bit.
- R4: With `filt_en`=1, a frame whose ninth bit is 0 is discarded whatever its byte.
- R5: With `filt_en`=1 and ninth bit 1, a frame is accepted when its byte equals the node address in every bit where the mask is 1. Bits where the mask is 0 are ignored.
- R6: With `filt_en`=1 and ninth bit 1, a frame is accepted when its byte has a 1 in every bit where (node address OR mask) is 1.
- R7: With `filt_en`=1, a frame with ninth bit 1 that meets neither R5 nor R6 is discarded.
- R8: With `filt_en`=1 and a mask of 0x00, every frame whose ninth bit is 1 is accepted.
- R9: An accepted frame raises `rx_take` for exactly one cycle, in the cycle after `frm_valid`. In that same cycle `rx_byte`/`rx_bit9` show the frame's byte and ninth bit. No `rx_take` occurs without a frame one cycle earlier.
- R10: A discarded frame raises no `rx_take` and leaves `rx_byte` and `rx_bit9` unchanged.
- R11: If a register write and a frame fall in the same cycle, the frame is judged against the register values from before the write. The new value applies from the next frame on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 node address, 1 mask |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Selected register value |
| filt_en | input | 1 | Address filtering enable |
| frm_valid | input | 1 | One-cycle strobe for a completed frame |
| frm_data | input | 8 | Received data byte |
| frm_bit9 | input | 1 | Received ninth bit |
| rx_take | output | 1 | One-cycle accept strobe |
| rx_byte | output | 8 | Receive buffer byte |
| rx_bit9 | output | 1 | Receive buffer ninth bit |

## Verification
A register write and a frame decision can land in the same cycle. The bench provokes this by writing a new node address or mask in the very cycle a frame is presented.

The scoreboard model computes that frame's verdict from the register values held before the write, and the model's registers are updated only afterwards. The frame that follows is then judged against the new values. A design that compared against the incoming write data would accept or reject the wrong frame of the pair.

// File: rtl/uart_mp_addr_filter.sv
module uart_mp_addr_filter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          filt_en,
  input  logic          frm_valid,
  input  logic [DW-1:0] frm_data,
  input  logic          frm_bit9,
  output logic          rx_take,
  output logic [DW-1:0] rx_byte,
  output logic          rx_bit9
);

  logic [DW-1:0] addr_q, mask_q, buf_q;
  logic          nine_q, take_q;

  wire [DW-1:0] bcast     = addr_q | mask_q;
  wire          own_hit   = ((frm_data ^ addr_q) & mask_q) == '0;
  wire          bcast_hit = (frm_data & bcast) == bcast;
  wire          addr_ok   = frm_bit9 && (own_hit || bcast_hit);
  wire          accept    = frm_valid && (!filt_en || addr_ok);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      mask_q <= '0;
    end else if (cfg_we) begin
      if (cfg_sel) mask_q <= cfg_wdata;
      else         addr_q <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      buf_q  <= '0;
      nine_q <= 1'b0;
    end else begin
      take_q <= accept;
      if (accept) begin
        buf_q  <= frm_data;
        nine_q <= frm_bit9;
      end
    end
  end

  assign cfg_rdata = cfg_sel ? mask_q : addr_q;
  assign rx_take   = take_q;
  assign rx_byte   = buf_q;
  assign rx_bit9   = nine_q;

  // R3
  unfiltered_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !filt_en) |=> rx_take);

  // R4
  no_bit9_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && filt_en && !frm_bit9) |=> !rx_take);

  // R9
  take_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !rx_take);

  // R10
  buffer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> ($stable(rx_byte) && $stable(rx_bit9)));

  // R2
  addr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> (addr_q == $past(cfg_wdata)));

  // R2
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel) |=> (mask_q == $past(cfg_wdata)));

  // R8
  open_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && filt_en && frm_bit9 && mask_q == '0) |=> rx_take);

endmodule

// File: tb/uart_mp_addr_filter_tb.sv
module uart_mp_addr_filter_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       filt_en = 1'b0, frm_valid = 1'b0, frm_bit9 = 1'b0;
  logic [7:0] frm_data = '0;
  logic       rx_take, rx_bit9;
  logic [7:0] rx_byte;

  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0] m_addr = '0, m_mask = '0, m_buf = '0;
  logic       m_nine = 1'b0;

  bit         q_take[$];
  logic [8:0] q_val[$];
  string      q_tag[$];
  bit         saw_frame = 0;

  uart_mp_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .filt_en(filt_en),
    .frm_valid(frm_valid), .frm_data(frm_data), .frm_bit9(frm_bit9),
    .rx_take(rx_take), .rx_byte(rx_byte), .rx_bit9(rx_bit9)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit model_accept(input logic [7:0] d, input logic n);
    logic [7:0] bc;
    bc = m_addr | m_mask;
    if (!filt_en) return 1'b1;
    if (!n) return 1'b0;
    return (((d ^ m_addr) & m_mask) == 8'h00) || ((d & bc) == bc);
  endfunction

  task automatic push_frame(input logic [7:0] d, input logic n, input string tag);
    bit acc;
    acc = model_accept(d, n);
    if (acc) begin m_buf = d; m_nine = n; end
    q_take.push_back(acc);
    q_val.push_back({m_nine, m_buf});
    q_tag.push_back(tag);
    frm_valid = 1'b1; frm_data = d; frm_bit9 = n;
  endtask

  task automatic send(input logic [7:0] d, input logic n, input string tag);
    @(negedge clk);
    push_frame(d, n, tag);
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    if (sel) m_mask = v; else m_addr = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // R11: frame judged with old values, model updated after the push
  task automatic wr_with_frame(input logic sel, input logic [7:0] v,
                               input logic [7:0] d, input logic n, input string tag);
    @(negedge clk);
    push_frame(d, n, tag);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
    if (sel) m_mask = v; else m_addr = v;
    @(negedge clk);
    cfg_we = 1'b0; frm_valid = 1'b0;
  endtask

  always @(posedge clk) saw_frame <= rst_n && frm_valid;

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (saw_frame) begin
        if (q_take.size() == 0) begin
          check(0, "R9", "frame with empty scoreboard", 9'h0, 9'h0);
        end else begin
          bit et; logic [8:0] ev; string tg;
          et = q_take.pop_front(); ev = q_val.pop_front(); tg = q_tag.pop_front();
          check(rx_take == et, tg, "rx_take", {8'h0, rx_take}, {8'h0, et});
          check({rx_bit9, rx_byte} == ev, et ? tg : "R10", "buffer",
                {rx_bit9, rx_byte}, ev);
        end
      end else if (rx_take) begin
        check(0, "R9", "strobe without frame", {8'h0, rx_take}, 9'h0);
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    cfg_sel = 1'b0; #1;
    check(cfg_rdata == 8'h00, "R1", "addr reset", {1'b0, cfg_rdata}, 9'h0);
    cfg_sel = 1'b1; #1;
    check(cfg_rdata == 8'h00, "R1", "mask reset", {1'b0, cfg_rdata}, 9'h0);
    check({rx_take, rx_bit9, rx_byte} == 10'h0, "R1", "outputs reset",
          {rx_bit9, rx_byte}, 9'h0);
    rst_n = 1'b1;

    // R2 write and readback
    wr(1'b0, 8'h5A);
    wr(1'b1, 8'hF0);
    cfg_sel = 1'b0; #1;
    check(cfg_rdata == 8'h5A, "R2", "addr readback", {1'b0, cfg_rdata}, 9'h05A);
    cfg_sel = 1'b1; #1;
    check(cfg_rdata == 8'hF0, "R2", "mask readback", {1'b0, cfg_rdata}, 9'h0F0);

    // R3 filter off
    filt_en = 1'b0;
    send(8'h12, 1'b0, "R3");
    send(8'hC3, 1'b1, "R3");
    send(8'h00, 1'b0, "R3");

    filt_en = 1'b1;
    // R4 ninth bit 0 dropped even when byte would match
    send(8'h5A, 1'b0, "R4");
    send(8'hFF, 1'b0, "R4");
    // R5 own address under mask F0
    send(8'h53, 1'b1, "R5");
    send(8'h5F, 1'b1, "R5");
    // R6 broadcast FA
    send(8'hFA, 1'b1, "R6");
    send(8'hFF, 1'b1, "R6");
    send(8'hFB, 1'b1, "R6");
    // R7 neither
    send(8'h63, 1'b1, "R7");
    send(8'hF8, 1'b1, "R7");
    send(8'h00, 1'b1, "R7");
    // R9 back-to-back frames
    @(negedge clk); push_frame(8'h55, 1'b1, "R9");
    @(negedge clk); push_frame(8'h40, 1'b1, "R9");
    @(negedge clk); push_frame(8'h5E, 1'b1, "R9");
    @(negedge clk); frm_valid = 1'b0;

    // R11 write and frame together
    wr_with_frame(1'b0, 8'h30, 8'h51, 1'b1, "R11");
    send(8'h51, 1'b1, "R11");
    send(8'h3C, 1'b1, "R11");
    wr_with_frame(1'b1, 8'h00, 8'h01, 1'b1, "R11");
    // R8 mask zero: broadcast 30, any byte matches via own address
    send(8'h01, 1'b1, "R8");
    send(8'hA5, 1'b1, "R8");
    send(8'h00, 1'b1, "R8");
    send(8'h00, 1'b0, "R4");

    // R5 exact full-mask compare
    wr(1'b1, 8'hFF);
    wr(1'b0, 8'h81);
    send(8'h81, 1'b1, "R5");
    send(8'h80, 1'b1, "R7");

    repeat (3) @(negedge clk);
    check(q_take.size() == 0, "R9", "scoreboard drained", q_take.size(), 9'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule